// File: doc/BRIEF.md
# Warp Reconvergence Stack

This block tracks the program counter and the active-lane mask of one warp whose lanes share a single instruction stream. Each cycle it is handed the decoded class of the instruction now at its PC, a branch or sync target, one predicate bit per lane and a convergence flag. From these it produces the PC and lane mask for the next instruction.

When lanes disagree on a branch, the taken lanes run first and the untaken lanes are saved on an internal stack, together with the fall-through PC. An explicit sync instruction records a reconvergence point on the same stack before any divergent code. An instruction that carries the convergence flag pops the stack. The pop either resumes a waiting path or, when the sync entry comes back, restores the saved mask at the reconvergence PC. Lanes may also retire through an exit class. A mask that empties this way triggers a pop in the same cycle.

Top module: `warp_recon_unit`

## Requirements
- R1: While reset is low and on release, `pc` equals RESET_PC (default 0), `activeMask` is all ones and `overflowErr` is 0.
- R2: An accepted instruction of class 0 (plain) without the convergence flag advances `pc` by one and leaves `activeMask` unchanged. Outputs change on the clock edge that accepts the instruction.
- R3: Class 1 (sync) advances `pc` by one, keeps the mask, and pushes an entry holding `branchTarget` and the current mask. A later pop of that entry sets `pc` to that target and `activeMask` to that saved mask.
- R4: For class 2 (branch), the taken lanes are `lanePred & activeMask`. When they form neither the empty set nor the whole active mask, `pc` becomes `branchTarget`, `activeMask` becomes the taken lanes, and the untaken lanes are pushed with resume PC `pc+1`.
- R5: A uniform branch pushes nothing and keeps the mask. If every active lane is taken, `pc` becomes `branchTarget`. If none is taken, `pc` becomes `pc+1`. Predicate bits of inactive lanes have no effect.
- R6: A plain instruction with `convFlag` set pops the top entry and loads its resume PC and mask. With an empty stack it acts as a plain step, `pc+1`.
- R7: `convFlag` has no effect on classes 1, 2 and 3.
- R8: Class 3 (exit) removes the lanes whose predicate is 1 from `activeMask`. If any lanes remain, `pc` advances by one.
- R9: If an exit leaves no active lane, the top entry is popped in the same cycle. With an empty stack, `pc` holds and `activeMask` becomes zero.
- R10: A push attempted while DEPTH (default 8) entries are held is dropped. `overflowErr` is 1 for the one cycle after it. PC and mask still update as for an accepted push.
- R11: A backward divergent branch forms a retry loop. Each iteration narrows the mask to the looping lanes. After the last lanes leave, successive convergence pops replay each group of exited lanes, and the sync entry then restores the full mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| instrClass | input | 2 | 0 plain, 1 sync, 2 branch, 3 exit |
| branchTarget | input | PC_W | Branch target or reconvergence PC |
| lanePred | input | LANES | Per-lane predicate (branch taken / lane exits) |
| convFlag | input | 1 | Instruction carries the convergence flag |
| pc | output | PC_W | PC of the next instruction |
| activeMask | output | LANES | Lanes that execute the next instruction |
| overflowErr | output | 1 | One-cycle pulse after a push dropped on a full stack |

## Verification
Branches are driven with a half/half predicate split, with predicates that agree across all active lanes, and with all-zero predicates. These patterns separate the divergent push from the two uniform outcomes. One uniform case sets predicate bits only on inactive lanes, which exposes any design that masks the predicate incorrectly. Exit patterns that leave some lanes and then none separate a plain mask update from the immediate pop. A backward-branch retry loop, whose exiting set grows each pass, checks that pending entries unwind in LIFO order before the sync entry restores the full mask. Filling the stack with sync pushes and then issuing a sync and a divergent branch shows that the push is dropped while the PC and mask still advance.

// File: rtl/recon_pkg.sv
package recon_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_SYNC   = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_EXIT   = 2'd3
  } instrClass_e;

  typedef enum logic [1:0] {
    PC_HOLD   = 2'd0,
    PC_INC    = 2'd1,
    PC_TARGET = 2'd2,
    PC_STACK  = 2'd3
  } pcSel_e;

  typedef enum logic [1:0] {
    MASK_HOLD   = 2'd0,
    MASK_TAKEN  = 2'd1,
    MASK_STACK  = 2'd2,
    MASK_REMAIN = 2'd3
  } maskSel_e;

  // strobes from control to datapath and stack
  typedef struct packed {
    logic     push;
    logic     pushSync;
    logic     pop;
    pcSel_e   pcSel;
    maskSel_e maskSel;
    logic     overflow;
  } strobe_t;

endpackage

// File: rtl/recon_ctrl.sv
module recon_ctrl
  import recon_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [1:0]       instrClass,
  input  logic             convFlag,
  input  logic [LANES-1:0] lanePred,
  input  logic [LANES-1:0] activeMask,
  input  logic             stackEmpty,
  input  logic             stackFull,
  output strobe_t          strobe,
  output logic [LANES-1:0] takenMask,
  output logic [LANES-1:0] remainMask
);

  instrClass_e cls;
  logic        pushReq;

  assign cls        = instrClass_e'(instrClass);
  assign takenMask  = lanePred & activeMask;
  assign remainMask = activeMask & ~lanePred;

  always_comb begin
    strobe  = '0;
    pushReq = 1'b0;
    if (instrValid) begin
      case (cls)
        CLS_PLAIN: begin
          if (convFlag && !stackEmpty) begin
            strobe.pop     = 1'b1;
            strobe.pcSel   = PC_STACK;
            strobe.maskSel = MASK_STACK;
          end else begin
            strobe.pcSel = PC_INC;
          end
        end
        CLS_SYNC: begin
          pushReq         = 1'b1;
          strobe.pushSync = 1'b1;
          strobe.pcSel    = PC_INC;
        end
        CLS_BRANCH: begin
          if (takenMask == '0) begin
            strobe.pcSel = PC_INC;
          end else if (takenMask == activeMask) begin
            strobe.pcSel = PC_TARGET;
          end else begin
            pushReq        = 1'b1;
            strobe.pcSel   = PC_TARGET;
            strobe.maskSel = MASK_TAKEN;
          end
        end
        default: begin
          if (remainMask == '0 && !stackEmpty) begin
            strobe.pop     = 1'b1;
            strobe.pcSel   = PC_STACK;
            strobe.maskSel = MASK_STACK;
          end else if (remainMask == '0) begin
            strobe.pcSel   = PC_HOLD;
            strobe.maskSel = MASK_REMAIN;
          end else begin
            strobe.pcSel   = PC_INC;
            strobe.maskSel = MASK_REMAIN;
          end
        end
      endcase
    end
    strobe.push     = pushReq && !stackFull;
    strobe.overflow = pushReq && stackFull;
  end

  // uniform branch must never record anything
  assert_uniform_nopush_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && cls == CLS_BRANCH && takenMask == activeMask) |-> !strobe.push);

  // convergence flag on a non-plain class never pops
  assert_flag_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && cls != CLS_PLAIN && cls != CLS_EXIT) |-> !strobe.pop);

endmodule

// File: rtl/recon_stack.sv
module recon_stack #(
  parameter int ENTRY_W = 64,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] pushEntry,
  output logic [ENTRY_W-1:0] topEntry,
  output logic               empty,
  output logic               full
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]    sp;
  logic [ENTRY_W-1:0] slotArr [DEPTH];
  logic [IDX_W-1:0]   topIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENTRY_W-1:0] q;
    always_ff @(posedge clk) begin
      if (push && sp == SP_W'(i)) q <= pushEntry;
    end
    assign slotArr[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp - 1'b1;
  end

  assign empty    = (sp == '0);
  assign full     = (sp == SP_W'(DEPTH));
  assign topIdx   = IDX_W'(sp - 1'b1);
  assign topEntry = empty ? '0 : slotArr[topIdx];

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

  assert_sp_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(DEPTH));

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rstN)
    push |=> (sp == $past(sp) + 1'b1));

endmodule

// File: rtl/recon_datapath.sv
module recon_datapath
  import recon_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int LANES    = 32,
  parameter int RESET_PC = 0,
  localparam int ENTRY_W = 2 * PC_W + LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [PC_W-1:0]    branchTarget,
  input  logic [LANES-1:0]   takenMask,
  input  logic [LANES-1:0]   remainMask,
  input  logic [ENTRY_W-1:0] topEntry,
  output logic [ENTRY_W-1:0] pushEntry,
  output logic [PC_W-1:0]    pc,
  output logic [LANES-1:0]   activeMask,
  output logic               overflowErr
);

  // entry layout: {convPc, nextPc, laneMask}
  logic [PC_W-1:0]  topConv;
  logic [PC_W-1:0]  topNext;
  logic [LANES-1:0] topMask;
  logic [PC_W-1:0]  pcPlusOne;

  assign {topConv, topNext, topMask} = topEntry;
  assign pcPlusOne = pc + 1'b1;

  always_comb begin
    if (strobe.pushSync)
      pushEntry = {branchTarget, branchTarget, activeMask};
    else
      pushEntry = {topConv, pcPlusOne, activeMask & ~takenMask};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc          <= PC_W'(RESET_PC);
      activeMask  <= '1;
      overflowErr <= 1'b0;
    end else begin
      overflowErr <= strobe.overflow;
      case (strobe.pcSel)
        PC_INC:    pc <= pcPlusOne;
        PC_TARGET: pc <= branchTarget;
        PC_STACK:  pc <= topNext;
        default:   ;
      endcase
      case (strobe.maskSel)
        MASK_TAKEN:  activeMask <= takenMask;
        MASK_STACK:  activeMask <= topMask;
        MASK_REMAIN: activeMask <= remainMask;
        default:     ;
      endcase
    end
  end

  assert_taken_subset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskSel == MASK_TAKEN) |=> ((activeMask & ~$past(activeMask)) == '0));

  assert_hold_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcSel == PC_HOLD && strobe.maskSel == MASK_REMAIN) |=> (activeMask == '0));

endmodule

// File: rtl/warp_recon_unit.sv
module warp_recon_unit
  import recon_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int LANES    = 32,
  parameter int DEPTH    = 8,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [1:0]       instrClass,
  input  logic [PC_W-1:0]  branchTarget,
  input  logic [LANES-1:0] lanePred,
  input  logic             convFlag,
  output logic [PC_W-1:0]  pc,
  output logic [LANES-1:0] activeMask,
  output logic             overflowErr
);

  localparam int ENTRY_W = 2 * PC_W + LANES;

  strobe_t            strobe;
  logic [LANES-1:0]   takenMask;
  logic [LANES-1:0]   remainMask;
  logic [ENTRY_W-1:0] pushEntry;
  logic [ENTRY_W-1:0] topEntry;
  logic               stackEmpty;
  logic               stackFull;

  recon_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrClass (instrClass),
    .convFlag   (convFlag),
    .lanePred   (lanePred),
    .activeMask (activeMask),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .strobe     (strobe),
    .takenMask  (takenMask),
    .remainMask (remainMask)
  );

  recon_stack #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rstN      (rstN),
    .push      (strobe.push),
    .pop       (strobe.pop),
    .pushEntry (pushEntry),
    .topEntry  (topEntry),
    .empty     (stackEmpty),
    .full      (stackFull)
  );

  recon_datapath #(.PC_W(PC_W), .LANES(LANES), .RESET_PC(RESET_PC)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .branchTarget (branchTarget),
    .takenMask    (takenMask),
    .remainMask   (remainMask),
    .topEntry     (topEntry),
    .pushEntry    (pushEntry),
    .pc           (pc),
    .activeMask   (activeMask),
    .overflowErr  (overflowErr)
  );

  assert_ovf_only_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> $past(stackFull));

endmodule

// File: tb/sim_warp_recon_unit.sv
module sim_warp_recon_unit;

  localparam int PC_W  = 16;
  localparam int LANES = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             instrValid = 1'b0;
  logic [1:0]       instrClass = 2'd0;
  logic [PC_W-1:0]  branchTarget = '0;
  logic [LANES-1:0] lanePred = '0;
  logic             convFlag = 1'b0;
  logic [PC_W-1:0]  pc;
  logic [LANES-1:0] activeMask;
  logic             overflowErr;

  int vecCount = 0;
  int errCount = 0;

  typedef struct {
    logic [PC_W-1:0]  expPc;
    logic [LANES-1:0] expMask;
    logic             expOvf;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  warp_recon_unit u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrClass(instrClass),
    .branchTarget(branchTarget), .lanePred(lanePred), .convFlag(convFlag),
    .pc(pc), .activeMask(activeMask), .overflowErr(overflowErr)
  );

  task automatic compare(string tag, logic [PC_W-1:0] ePc, logic [LANES-1:0] eMask, logic eOvf);
    vecCount++;
    if (pc !== ePc || activeMask !== eMask || overflowErr !== eOvf) begin
      errCount++;
      $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
               tag, pc, activeMask, overflowErr, ePc, eMask, eOvf);
    end
  endtask

  // monitor: one expected item per accepted instruction
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      compare(it.tag, it.expPc, it.expMask, it.expOvf);
    end
  end

  task automatic issue(logic [1:0] cls, logic [PC_W-1:0] tgt, logic [LANES-1:0] pred,
                       logic conv, logic [PC_W-1:0] ePc, logic [LANES-1:0] eMask,
                       logic eOvf, string tag);
    expItem_t it;
    @(negedge clk);
    instrValid   = 1'b1;
    instrClass   = cls;
    branchTarget = tgt;
    lanePred     = pred;
    convFlag     = conv;
    it.expPc = ePc; it.expMask = eMask; it.expOvf = eOvf; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    instrValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    compare({tag, " in reset"}, '0, '1, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    compare({tag, " after release"}, '0, '1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    doReset("R1");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h01, 32'hFFFFFFFF, 1'b0, "R2 plain step");
    issue(2'd1, 16'h20, 32'h0,        1'b0, 16'h02, 32'hFFFFFFFF, 1'b0, "R3 sync push");
    issue(2'd2, 16'h10, 32'h0000FFFF, 1'b0, 16'h10, 32'h0000FFFF, 1'b0, "R4 divergent branch");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h11, 32'h0000FFFF, 1'b0, "R2 plain on taken path");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h03, 32'hFFFF0000, 1'b0, "R6 pop pending path");
    issue(2'd2, 16'h40, 32'hFFFF0001, 1'b0, 16'h40, 32'hFFFF0000, 1'b0, "R5 uniform taken, inactive pred ignored");
    issue(2'd2, 16'h60, 32'h0000FFFF, 1'b0, 16'h41, 32'hFFFF0000, 1'b0, "R5 uniform not taken");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h20, 32'hFFFFFFFF, 1'b0, "R3 R6 pop sync entry");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h21, 32'hFFFFFFFF, 1'b0, "R6 flag on empty stack");
    issue(2'd1, 16'h50, 32'h0,        1'b1, 16'h22, 32'hFFFFFFFF, 1'b0, "R7 flag ignored on sync");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h23, 32'hFFFFFFFF, 1'b0, "R2 plain");
    issue(2'd3, 16'h0,  32'h0000000F, 1'b1, 16'h24, 32'hFFFFFFF0, 1'b0, "R8 R7 partial exit");
    issue(2'd3, 16'h0,  32'hFFFFFFF0, 1'b0, 16'h50, 32'hFFFFFFFF, 1'b0, "R9 empty mask pops sync");
    issue(2'd3, 16'h0,  32'hFFFFFFFF, 1'b0, 16'h50, 32'h00000000, 1'b0, "R9 empty mask, empty stack");

    doReset("R1 second");
    issue(2'd1, 16'h06, 32'h0,        1'b0, 16'h01, 32'hFFFFFFFF, 1'b0, "R11 sync before loop");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h02, 32'hFFFFFFFF, 1'b0, "R11 loop body");
    issue(2'd2, 16'h01, 32'hFFFFFFF0, 1'b0, 16'h01, 32'hFFFFFFF0, 1'b0, "R11 first back branch");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h02, 32'hFFFFFFF0, 1'b0, "R11 loop body 2");
    issue(2'd2, 16'h01, 32'hFFFFFF00, 1'b0, 16'h01, 32'hFFFFFF00, 1'b0, "R11 second back branch");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h02, 32'hFFFFFF00, 1'b0, "R11 loop body 3");
    issue(2'd2, 16'h01, 32'h0,        1'b0, 16'h03, 32'hFFFFFF00, 1'b0, "R11 all leave loop");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h03, 32'h000000F0, 1'b0, "R11 replay second group");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h03, 32'h0000000F, 1'b0, "R11 replay first group");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h06, 32'hFFFFFFFF, 1'b0, "R11 full mask restored");

    doReset("R1 third");
    for (int i = 0; i < 8; i++)
      issue(2'd1, 16'h100 + 16'(i), 32'h0, 1'b0, 16'(i + 1), 32'hFFFFFFFF, 1'b0, "R10 fill stack");
    issue(2'd1, 16'h1FF, 32'h0,       1'b0, 16'h09, 32'hFFFFFFFF, 1'b1, "R10 sync on full stack");
    issue(2'd0, 16'h0,  32'h0,        1'b0, 16'h0A, 32'hFFFFFFFF, 1'b0, "R10 error is one cycle");
    issue(2'd2, 16'h30, 32'h00000001, 1'b0, 16'h30, 32'h00000001, 1'b1, "R10 divergent on full stack");
    issue(2'd0, 16'h0,  32'h0,        1'b1, 16'h107, 32'hFFFFFFFF, 1'b0, "R10 dropped push, top intact");

    @(negedge clk);
    instrValid = 1'b0;
    convFlag   = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule